// File: doc/BRIEF.md
# Host Port FIFO Bridge with Debug Suspend

The bridge connects an external host bus to an internal memory port driven by a simple request/acknowledge handshake. Host data writes are posted into a write queue. A DMA engine writes each entry to memory at a write pointer that advances by one word per transfer. Toward the host, a read queue is kept filled by prefetching from memory at a read pointer, so host data reads are normally served without waiting. A small control register and the two pointers can be read and written by the host at any time.

A debug-halt input can freeze the memory side. Two control bits decide whether it does: a "keep running" bit that overrides everything, and a "stop on halt" bit. When the halt applies, the engine finishes a transfer that is already requested and then issues nothing new. The host side keeps working until a queue condition blocks it. The ready output then holds the host cycle off until the halt ends and the engine has serviced the queue.

Top module: `hostq_bridge`

## Requirements
- R1: A host write with `host_reg` = 0 (data) posts the word into the write queue. The engine writes the posted words to memory in posting order (`dma_we` = 1), at the write pointer, and adds 4 to the pointer after each acknowledged write.
- R2: While the read queue has room, the engine requests reads (`dma_we` = 0) at the read pointer and adds 4 to the pointer after each acknowledged read. Host reads with `host_reg` = 0 return the fetched words in address order.
- R3: Each queue holds 8 words. `host_rdy` is low during a data write while the write queue is full and during a data read while the read queue is empty. A host cycle completes on the first rising edge at which `host_sel` and `host_rdy` are both high.
- R4: Register codes on `host_reg`: 1 = control, 2 = write pointer, 3 = read pointer. All three can be written and read back. Control bit 0 is "keep running" and bit 1 is "stop on halt", and both reset to 0. Register accesses never wait.
- R5: With control bit 0 set, `dbg_halt` has no effect, whatever the value of bit 1.
- R6: With both control bits clear, `dbg_halt` has no effect.
- R7: With bit 0 clear and bit 1 set, `dbg_halt` is sampled on a clock edge. From the following edge on, no new request is raised while the halt remains.
- R8: While halted, the host can still access all registers. It can write data until the write queue is full and read data until the read queue is empty.
- R9: A data cycle stalled during a halt keeps `host_rdy` low until the halt is released and the engine has made room or data. The cycle then completes exactly once, with no word lost or repeated.
- R10: After a halt is released, the engine drains the write queue and refills the read queue without further host action.
- R11: A host write to either pointer register empties the read queue. A read already in flight at that moment is discarded and does not advance the read pointer.
- R12: Once raised, `dma_req` stays high, with `dma_we`, `dma_addr` and `dma_wdata` unchanged, until `dma_ack` is seen. A transfer is never aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host cycle strobe, held until accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | 0 data, 1 control, 2 write pointer, 3 read pointer |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_rdy | output | 1 | Cycle can complete this edge |
| dbg_halt | input | 1 | Debug halt request |
| dma_req | output | 1 | Memory transfer request |
| dma_we | output | 1 | 1 = memory write, 0 = memory read |
| dma_addr | output | 32 | Transfer byte address |
| dma_wdata | output | 32 | Memory write data |
| dma_ack | input | 1 | One-cycle acknowledge of the current request |
| dma_rdata | input | 32 | Read data, valid with the acknowledge |

## Verification
The assertions assume that `dma_ack` is a single-cycle pulse that is seen only while `dma_req` is high. They also assume the host holds `host_wr`, `host_reg` and `host_wdata` steady from the time it raises `host_sel` until the cycle is accepted. The bench memory model acknowledges a request at most once, and only on the cycle after it sees the request, and can be paused to keep a request pending. The host task drives a cycle at a falling edge, holds it until ready is seen, and drops the strobe right after the accepting edge. The stimulus therefore stays inside these assumptions.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
  typedef enum logic [1:0] {
    HREG_DATA  = 2'd0,
    HREG_CTRL  = 2'd1,
    HREG_WADDR = 2'd2,
    HREG_RADDR = 2'd3
  } hreg_e;

  localparam int CTRL_W        = 2;
  localparam int CTRL_FREE_BIT = 0;
  localparam int CTRL_STOP_BIT = 1;
endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  input  logic                         flush,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH):0]       count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[rp_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/hostq_dma.sv
module hostq_dma #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          no_issue,
  input  logic          wf_empty,
  input  logic [DW-1:0] wf_head,
  input  logic          rf_full,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] raddr,
  input  logic          dma_ack,
  output logic          dma_req,
  output logic          dma_we,
  output logic [DW-1:0] dma_addr,
  output logic [DW-1:0] dma_wdata
);
  logic          req_q, req_d, we_q, we_d;
  logic [DW-1:0] addr_q, addr_d, wd_q, wd_d;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (req_q) begin
      if (dma_ack) req_d = 1'b0;
    end else if (!no_issue) begin
      if (!wf_empty) begin
        req_d  = 1'b1;
        we_d   = 1'b1;
        addr_d = waddr;
        wd_d   = wf_head;
      end else if (!rf_full) begin
        req_d  = 1'b1;
        we_d   = 1'b0;
        addr_d = raddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  assign dma_req   = req_q;
  assign dma_we    = we_q;
  assign dma_addr  = addr_q;
  assign dma_wdata = wd_q;
endmodule

// File: rtl/hostq_bridge.sv
module hostq_bridge
  import hostq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [1:0]    host_reg,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  input  logic          dbg_halt,
  output logic          dma_req,
  output logic          dma_we,
  output logic [DW-1:0] dma_addr,
  output logic [DW-1:0] dma_wdata,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_rdata
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int STEP = DW / 8;

  hreg_e             rsel;
  logic              h_data, fire;
  logic              wf_push, rf_pop, rf_push;
  logic              ctrl_wr, waddr_wr, raddr_wr, addr_wr;
  logic              wr_done, rd_done;
  logic              wf_full, wf_empty, rf_full, rf_empty;
  logic [DW-1:0]     wf_head, rf_head;
  logic [CW-1:0]     wf_count, rf_count;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     waddr_q, waddr_d, raddr_q, raddr_d;
  logic              halt_s_q, halt_s_d, drop_q, drop_d, halt_q;

  // host decode
  assign rsel     = hreg_e'(host_reg);
  assign h_data   = host_sel && (rsel == HREG_DATA);
  assign host_rdy = !h_data || (host_wr ? !wf_full : !rf_empty);
  assign fire     = host_sel && host_rdy;
  assign wf_push  = fire && host_wr && (rsel == HREG_DATA);
  assign rf_pop   = fire && !host_wr && (rsel == HREG_DATA);
  assign ctrl_wr  = fire && host_wr && (rsel == HREG_CTRL);
  assign waddr_wr = fire && host_wr && (rsel == HREG_WADDR);
  assign raddr_wr = fire && host_wr && (rsel == HREG_RADDR);
  assign addr_wr  = waddr_wr || raddr_wr;

  always_comb begin
    case (rsel)
      HREG_CTRL:  host_rdata = DW'(ctrl_q);
      HREG_WADDR: host_rdata = waddr_q;
      HREG_RADDR: host_rdata = raddr_q;
      default:    host_rdata = rf_head;
    endcase
  end

  // transfer completion and suspend qualification
  assign wr_done = dma_req && dma_ack && dma_we;
  assign rd_done = dma_req && dma_ack && !dma_we;
  assign rf_push = rd_done && !drop_q && !addr_wr;
  assign halt_q  = halt_s_q && ctrl_q[CTRL_STOP_BIT] && !ctrl_q[CTRL_FREE_BIT];

  always_comb begin
    ctrl_d   = ctrl_q;
    waddr_d  = waddr_q;
    raddr_d  = raddr_q;
    drop_d   = drop_q;
    halt_s_d = dbg_halt;
    if (ctrl_wr) ctrl_d = host_wdata[CTRL_W-1:0];
    if (waddr_wr)     waddr_d = host_wdata;
    else if (wr_done) waddr_d = waddr_q + DW'(STEP);
    if (raddr_wr)                 raddr_d = host_wdata;
    else if (rd_done && !drop_q)  raddr_d = raddr_q + DW'(STEP);
    if (rd_done) drop_d = 1'b0;
    if (addr_wr && dma_req && !dma_we && !dma_ack) drop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      waddr_q  <= '0;
      raddr_q  <= '0;
      drop_q   <= 1'b0;
      halt_s_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      waddr_q  <= waddr_d;
      raddr_q  <= raddr_d;
      drop_q   <= drop_d;
      halt_s_q <= halt_s_d;
    end
  end

  hostq_fifo #(.W(DW), .DEPTH(DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .push(wf_push), .wdata(host_wdata),
    .pop(wr_done), .flush(1'b0), .rdata(wf_head),
    .full(wf_full), .empty(wf_empty), .count(wf_count)
  );

  hostq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .push(rf_push), .wdata(dma_rdata),
    .pop(rf_pop), .flush(addr_wr), .rdata(rf_head),
    .full(rf_full), .empty(rf_empty), .count(rf_count)
  );

  hostq_dma #(.DW(DW)) u_dma (
    .clk(clk), .rst_n(rst_n), .no_issue(halt_q || addr_wr),
    .wf_empty(wf_empty), .wf_head(wf_head), .rf_full(rf_full),
    .waddr(waddr_q), .raddr(raddr_q), .dma_ack(dma_ack),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata)
  );
endmodule

// File: rtl/hostq_bridge_chk.sv
module hostq_bridge_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    host_sel,
  input logic                    host_wr,
  input logic [1:0]              host_reg,
  input logic                    host_rdy,
  input logic                    dma_req,
  input logic                    dma_we,
  input logic                    dma_ack,
  input logic [DW-1:0]           dma_addr,
  input logic [DW-1:0]           dma_wdata,
  input logic                    halt_q,
  input logic                    wf_full,
  input logic                    rf_empty,
  input logic [$clog2(DEPTH):0]  wf_count,
  input logic [$clog2(DEPTH):0]  rf_count
);
  AST_NO_NEW_REQ_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && halt_q) |=> !dma_req); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_we) && $stable(dma_addr) && $stable(dma_wdata))); // R12

  AST_WR_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_reg == 2'd0 && wf_full) |-> !host_rdy); // R3

  AST_RD_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_reg == 2'd0 && rf_empty) |-> !host_rdy); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_count <= ($clog2(DEPTH)+1)'(DEPTH)) && (rf_count <= ($clog2(DEPTH)+1)'(DEPTH))); // R3

  AST_REG_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_reg != 2'd0) |-> host_rdy); // R4
endmodule

bind hostq_bridge hostq_bridge_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_reg(host_reg), .host_rdy(host_rdy), .dma_req(dma_req), .dma_we(dma_we),
  .dma_ack(dma_ack), .dma_addr(dma_addr), .dma_wdata(dma_wdata), .halt_q(halt_q),
  .wf_full(wf_full), .rf_empty(rf_empty), .wf_count(wf_count), .rf_count(rf_count)
);

// File: tb/hostq_bridge_test.sv
module hostq_bridge_test;
  logic        clk, rst_n;
  logic        host_sel, host_wr, host_rdy, dbg_halt;
  logic [1:0]  host_reg;
  logic [31:0] host_wdata, host_rdata;
  logic        dma_req, dma_we, dma_ack;
  logic [31:0] dma_addr, dma_wdata, dma_rdata;

  int total = 0, bad = 0;
  logic        h_done, mem_en, halt_expect, prev_req;
  int          viol = 0, wn = 0;
  logic [31:0] wlog_a [64];
  logic [31:0] wlog_d [64];
  logic [31:0] rdv, wexp, rexp;
  int          wn0;

  // {keep running, stop on halt, expected blocked}
  localparam logic [2:0] MODE_TBL [4] = '{3'b000, 3'b011, 3'b100, 3'b110};

  hostq_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdy(host_rdy), .dbg_halt(dbg_halt), .dma_req(dma_req), .dma_we(dma_we),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic [1:0] rg, input logic [31:0] wd,
                         output logic [31:0] rd);
    int n;
    n = 0;
    h_done = 1'b0;
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_reg = rg; host_wdata = wd;
    #1;
    while (!host_rdy && n < 5000) begin
      @(negedge clk); #1; n++;
    end
    rd = host_rdata;
    @(posedge clk);
    #1;
    host_sel = 1'b0;
    h_done = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory model: one-cycle ack, pausable; also watches for requests raised while halted
  initial begin
    dma_ack = 1'b0; dma_rdata = '0; prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if (dma_ack) dma_ack = 1'b0;
      else if (dma_req && mem_en) begin
        dma_ack = 1'b1;
        if (dma_we) begin
          if (wn < 64) begin wlog_a[wn] = dma_addr; wlog_d[wn] = dma_wdata; end
          wn++;
        end else dma_rdata = pat(dma_addr);
      end
      if (dma_req && !prev_req && halt_expect) viol++;
      prev_req = dma_req;
    end
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_reg = 2'd0; host_wdata = '0;
    dbg_halt = 1'b0; mem_en = 1'b1; halt_expect = 1'b0; h_done = 1'b0;
    idle(4);
    chk(dma_req == 1'b0, "R12 reset req", {31'd0, dma_req}, 32'd0);
    chk(host_rdy == 1'b1, "R3 reset rdy", {31'd0, host_rdy}, 32'd1);
    rst_n = 1'b1;
    idle(30);

    // R4 register access
    host_op(1'b0, 2'd1, 0, rdv);
    chk(rdv == 32'd0, "R4 ctrl reset", rdv, 32'd0);
    host_op(1'b1, 2'd2, 32'h100, rdv); wexp = 32'h100;
    host_op(1'b0, 2'd2, 0, rdv);
    chk(rdv == 32'h100, "R4 waddr readback", rdv, 32'h100);
    host_op(1'b1, 2'd3, 32'h200, rdv); rexp = 32'h200;
    host_op(1'b0, 2'd3, 0, rdv);
    chk(rdv == 32'h200, "R4 raddr readback", rdv, 32'h200);

    // R2 / R11 prefetch after flush
    for (int k = 0; k < 10; k++) begin
      host_op(1'b0, 2'd0, 0, rdv);
      chk(rdv == pat(rexp), "R2 R11 read data", rdv, pat(rexp));
      rexp += 4;
    end

    // R1 posted writes
    wn0 = wn;
    for (int k = 0; k < 5; k++) host_op(1'b1, 2'd0, 32'hA000_0000 + k, rdv);
    idle(30);
    chk(wn == wn0 + 5, "R1 write count", wn, wn0 + 5);
    for (int k = 0; k < 5; k++) begin
      chk(wlog_a[wn0+k] == wexp, "R1 write addr", wlog_a[wn0+k], wexp);
      chk(wlog_d[wn0+k] == 32'hA000_0000 + k, "R1 write data", wlog_d[wn0+k], 32'hA000_0000 + k);
      wexp += 4;
    end

    // R5 R6 R7 mode table
    for (int m = 0; m < 4; m++) begin
      host_op(1'b1, 2'd1, {30'd0, MODE_TBL[m][1], MODE_TBL[m][2]}, rdv);
      idle(30);
      wn0 = wn;
      @(negedge clk); dbg_halt = 1'b1;
      idle(3); #1;
      halt_expect = MODE_TBL[m][0];
      host_op(1'b1, 2'd0, 32'hB000_0000 + m, rdv);
      idle(20);
      if (MODE_TBL[m][0])
        chk(wn == wn0, "R7 halted no write", wn, wn0);
      else
        chk(wn == wn0 + 1, "R5 R6 halt ignored", wn, wn0 + 1);
      halt_expect = 1'b0;
      @(negedge clk); dbg_halt = 1'b0;
      idle(20);
      chk(wn == wn0 + 1 && wlog_a[wn0] == wexp && wlog_d[wn0] == 32'hB000_0000 + m,
          "R10 mode write out", wlog_d[wn0], 32'hB000_0000 + m);
      wexp += 4;
    end

    // R8 R9 R10 write stall across halt (control = stop on halt)
    host_op(1'b1, 2'd1, 32'h2, rdv);
    idle(30);
    wn0 = wn;
    @(negedge clk); dbg_halt = 1'b1;
    idle(3); #1; halt_expect = 1'b1;
    for (int k = 0; k < 8; k++) host_op(1'b1, 2'd0, 32'hC000_0000 + k, rdv);
    host_op(1'b0, 2'd2, 0, rdv);
    chk(rdv == wexp, "R8 reg read while halted", rdv, wexp);
    fork
      host_op(1'b1, 2'd0, 32'hC000_0008, rdv);
      begin
        idle(20);
        chk(h_done == 1'b0, "R9 write stalled", {31'd0, h_done}, 32'd0);
        chk(host_rdy == 1'b0, "R9 rdy low", {31'd0, host_rdy}, 32'd0);
        chk(wn == wn0, "R7 nothing written", wn, wn0);
        halt_expect = 1'b0;
        dbg_halt = 1'b0;
      end
    join
    idle(40);
    chk(wn == wn0 + 9, "R9 R10 drained once", wn, wn0 + 9);
    for (int k = 0; k < 9; k++) begin
      chk(wlog_a[wn0+k] == wexp && wlog_d[wn0+k] == 32'hC000_0000 + k,
          "R9 order", wlog_d[wn0+k], 32'hC000_0000 + k);
      wexp += 4;
    end

    // R8 R9 R10 read stall across halt
    idle(30);
    @(negedge clk); dbg_halt = 1'b1;
    idle(3); #1; halt_expect = 1'b1;
    for (int k = 0; k < 8; k++) begin
      host_op(1'b0, 2'd0, 0, rdv);
      chk(rdv == pat(rexp), "R8 read while halted", rdv, pat(rexp));
      rexp += 4;
    end
    fork
      host_op(1'b0, 2'd0, 0, rdv);
      begin
        idle(20);
        chk(h_done == 1'b0, "R9 read stalled", {31'd0, h_done}, 32'd0);
        halt_expect = 1'b0;
        dbg_halt = 1'b0;
      end
    join
    chk(rdv == pat(rexp), "R9 R10 read after release", rdv, pat(rexp));
    rexp += 4;
    host_op(1'b0, 2'd0, 0, rdv);
    chk(rdv == pat(rexp), "R9 no duplicate", rdv, pat(rexp));
    rexp += 4;
    chk(viol == 0, "R7 no request while halted", viol, 0);

    // R3 full/empty stalls without halt
    host_op(1'b1, 2'd1, 32'h0, rdv);
    idle(30);
    mem_en = 1'b0;
    wn0 = wn;
    for (int k = 0; k < 8; k++) host_op(1'b1, 2'd0, 32'hD000_0000 + k, rdv);
    fork
      host_op(1'b1, 2'd0, 32'hD000_0008, rdv);
      begin
        idle(10);
        chk(host_rdy == 1'b0 && h_done == 1'b0, "R3 write full stall", {31'd0, host_rdy}, 32'd0);
        mem_en = 1'b1;
      end
    join
    idle(40);
    chk(wn == wn0 + 9 && wlog_d[wn0+8] == 32'hD000_0008, "R3 write completes", wn, wn0 + 9);
    wexp += 36;
    idle(30);
    mem_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      host_op(1'b0, 2'd0, 0, rdv);
      rexp += 4;
    end
    fork
      host_op(1'b0, 2'd0, 0, rdv);
      begin
        idle(10);
        chk(host_rdy == 1'b0 && h_done == 1'b0, "R3 read empty stall", {31'd0, host_rdy}, 32'd0);
        mem_en = 1'b1;
      end
    join
    chk(rdv == pat(rexp), "R3 read completes", rdv, pat(rexp));
    rexp += 4;

    // R11 R12 in-flight read discarded on pointer write
    idle(30);
    mem_en = 1'b0;
    host_op(1'b0, 2'd0, 0, rdv);
    chk(rdv == pat(rexp), "R2 read before flush", rdv, pat(rexp));
    idle(3);
    wn0 = dma_addr;
    chk(dma_req == 1'b1 && dma_we == 1'b0, "R12 read pending", {31'd0, dma_req}, 32'd1);
    idle(10);
    chk(dma_req == 1'b1 && dma_addr == wn0, "R12 request held", dma_addr, wn0);
    host_op(1'b1, 2'd3, 32'h400, rdv); rexp = 32'h400;
    mem_en = 1'b1;
    host_op(1'b0, 2'd0, 0, rdv);
    chk(rdv == pat(rexp), "R11 stale read dropped", rdv, pat(rexp));
    host_op(1'b0, 2'd0, 0, rdv);
    chk(rdv == pat(rexp + 4), "R11 sequence after flush", rdv, pat(rexp + 4));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule